// File: doc/BRIEF.md
# Timestamped Event Capture Unit

This block watches a small set of digital input lines and records when they change. Each input passes through a two-flop synchronizer and then an edge detector. A two-bit code per input selects which transitions count as events. Every detected event is tagged with the value of a free-running timebase that advances once for every fixed group of state times. All inputs that fire in the same clock cycle share one record, which holds a mask of those inputs and a single time tag.

Records enter a small FIFO. The FIFO feeds a single holding register, which the processor reads through a register-style port. Moving a record from the FIFO into an empty holding register always takes a fixed number of state times. A read clears the holding register. If the FIFO is full when a new event arrives, that event is dropped and a sticky overflow flag is set. The flag clears on the next read.

Top module: `evcap_unit`

## Requirements
- R1: Per input i, `mode_cfg[2i+1:2i]` selects detection: 00 disabled, 01 rising edges only, 10 falling edges only, 11 both edges. A transition of the wrong polarity produces no record.
- R2: The timebase starts at 0 after reset and advances by one after every 8 cycles in which `state_tick` is high, wrapping at 2^16. A record's tag equals the timebase value in its detection cycle. The detection cycle follows the second rising clock edge after the input changes.
- R3: Inputs that fire in the same detection cycle produce exactly one record. Bit i of its mask is set for each input i that fired.
- R4: An input whose mode is 00 never creates a record and never sets a mask bit, whatever its activity.
- R5: After reset the holding register is empty (`rd_valid`=0, `rd_mask`=0, `rd_tag`=0), `fifo_empty`=1, `fifo_full`=0 and `overflow`=0. `fifo_empty` and `fifo_full` are never both high.
- R6: When the holding register is empty and the FIFO is not, the head record moves into the holding register on the 8th state tick after the record became available. With `state_tick` held high, `rd_valid` rises 11 clock edges after the input change.
- R7: When the FIFO held a single record, the FIFO is empty again after that record moves into the holding register.
- R8: A cycle with `rd_en` high while `rd_valid` is high clears the holding register. Any following FIFO entry then moves in after the same 8-state-tick delay.
- R9: An event that finds the FIFO full (8 entries) is dropped and sets `overflow`. `overflow` stays set until a read (`rd_en` high) in a cycle where no new drop occurs.
- R10: Records leave through the holding register in the order their events were detected. Each one carries its mask and tag unchanged.
- R11: While `rd_valid` is high and `rd_en` is low, the holding register contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| state_tick | input | 1 | One pulse per state time; drives the timebase and the transfer delay |
| ev_in | input | 4 | Asynchronous event inputs |
| mode_cfg | input | 8 | Two-bit detect mode per input |
| rd_en | input | 1 | Read strobe; consumes the holding register and clears overflow |
| rd_valid | output | 1 | Holding register contains a record |
| rd_mask | output | 4 | Inputs that fired for the held record |
| rd_tag | output | 16 | Time tag of the held record |
| fifo_empty | output | 1 | FIFO has no entries |
| fifo_full | output | 1 | FIFO holds its full depth |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
A wrong prescaler or timebase state shows up as tags that drift from the expected value. The error becomes visible from the first record read after the timebase first wraps its prescaler, eight state times into the run. A wrong transfer-delay count shows up as `rd_valid` rising one or more cycles early or late, on the very first record. A corrupted FIFO pointer or count shows up as records out of order, repeated or missing at the next read. The overflow and full flags show it as soon as the ninth record is stored. A stuck edge-detector state gives missing or extra records within three cycles of the input change.

// File: rtl/evcap_pkg.sv
package evcap_pkg;

  typedef enum logic [1:0] {
    DET_OFF  = 2'b00,
    DET_RISE = 2'b01,
    DET_FALL = 2'b10,
    DET_BOTH = 2'b11
  } det_mode_e;

  function automatic logic edge_hit(input det_mode_e mode, input logic cur, input logic prev);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    case (mode)
      DET_RISE: edge_hit = rise;
      DET_FALL: edge_hit = fall;
      DET_BOTH: edge_hit = rise | fall;
      default:  edge_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evcap_edge.sv
module evcap_edge #(
  parameter int N_IN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   ev_in,
  input  logic [2*N_IN-1:0] mode_cfg,
  output logic [N_IN-1:0]   hit
);
  import evcap_pkg::*;

  for (genvar i = 0; i < N_IN; i++) begin : g_line
    logic meta_q, sync_q, last_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= ev_in[i];
        sync_q <= meta_q;
        last_q <= sync_q;
      end
    end

    assign hit[i] = edge_hit(det_mode_e'(mode_cfg[2*i +: 2]), sync_q, last_q);
  end

endmodule

// File: rtl/evcap_timebase.sv
module evcap_timebase #(
  parameter int TAG_W    = 16,
  parameter int TICK_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             state_tick,
  output logic [TAG_W-1:0] tag
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      tag   <= '0;
    end else if (state_tick) begin
      if (pre_q == PLAST) begin
        pre_q <= '0;
        tag   <= tag + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/evcap_fifo.sv
module evcap_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] ALAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CFULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CFULL);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == ALAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == ALAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/evcap_unit.sv
module evcap_unit #(
  parameter int N_IN       = 4,
  parameter int TAG_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int TICK_DIV   = 8,
  parameter int XFER_DELAY = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              state_tick,
  input  logic [N_IN-1:0]   ev_in,
  input  logic [2*N_IN-1:0] mode_cfg,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [N_IN-1:0]   rd_mask,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic              overflow
);
  localparam int REC_W = N_IN + TAG_W;
  localparam int DW    = $clog2(XFER_DELAY + 1);
  localparam logic [DW-1:0] DLAST = DW'(XFER_DELAY - 1);

  logic [N_IN-1:0]  hit;
  logic [TAG_W-1:0] now_tag;
  logic [REC_W-1:0] head_rec;
  logic             any_hit, move, drop;
  logic [DW-1:0]    dly_q;

  evcap_edge #(.N_IN(N_IN)) u_edge (
    .clk(clk), .rst(rst), .ev_in(ev_in), .mode_cfg(mode_cfg), .hit(hit)
  );

  evcap_timebase #(.TAG_W(TAG_W), .TICK_DIV(TICK_DIV)) u_tb (
    .clk(clk), .rst(rst), .state_tick(state_tick), .tag(now_tag)
  );

  assign any_hit = |hit;
  assign drop    = any_hit && fifo_full;
  assign move    = !rd_valid && !fifo_empty && state_tick && (dly_q == DLAST);

  evcap_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(any_hit), .wdata({hit, now_tag}),
    .pop(move), .rdata(head_rec),
    .empty(fifo_empty), .full(fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
    end else if (rd_valid || fifo_empty || move) begin
      dly_q <= '0;
    end else if (state_tick) begin
      dly_q <= dly_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_mask  <= '0;
      rd_tag   <= '0;
    end else if (move) begin
      rd_valid <= 1'b1;
      rd_mask  <= head_rec[REC_W-1:TAG_W];
      rd_tag   <= head_rec[TAG_W-1:0];
    end else if (rd_en) begin
      rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        overflow <= 1'b0;
    else if (drop)  overflow <= 1'b1;
    else if (rd_en) overflow <= 1'b0;
  end

endmodule

// File: rtl/evcap_unit_chk.sv
module evcap_unit_chk #(
  parameter int N_IN  = 4,
  parameter int TAG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [N_IN-1:0]  rd_mask,
  input logic [TAG_W-1:0] rd_tag,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic             overflow
);

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  a_r9_ovf_needs_full: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(fifo_full));

  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !fifo_full) |=> !overflow);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_valid) |=> !rd_valid);

  a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_mask) && $stable(rd_tag)));

  a_r6_fill_from_fifo: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> $past(!fifo_empty));

  a_r3_mask_nonzero: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_mask != '0));

endmodule

bind evcap_unit evcap_unit_chk #(.N_IN(N_IN), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/tb_evcap_unit.sv
module tb_evcap_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        state_tick = 1'b1;
  logic [3:0]  ev_in = 4'b0000;
  logic [7:0]  mode_cfg = 8'b00_11_10_01; // in3 off, in2 both, in1 falling, in0 rising (R1)
  logic        rd_en = 1'b0;
  logic        rd_valid, fifo_empty, fifo_full, overflow;
  logic [3:0]  rd_mask;
  logic [15:0] rd_tag;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          drain_on = 1'b0;
  logic [19:0] expq[$];
  string       lblq[$];
  int unsigned tb_ticks;

  always #4 clk = ~clk;

  evcap_unit dut (
    .clk(clk), .rst(rst), .state_tick(state_tick), .ev_in(ev_in), .mode_cfg(mode_cfg),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_mask(rd_mask), .rd_tag(rd_tag),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow(overflow)
  );

  // Independent timebase model (R2): one count per 8 state ticks.
  always @(posedge clk) begin
    if (rst) tb_ticks <= 0;
    else if (state_tick) tb_ticks <= tb_ticks + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: change inputs, push the expected record at the detection cycle.
  task automatic fire(logic [3:0] v, logic [3:0] m, bit dropped, string lbl);
    @(negedge clk);
    ev_in = v;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (m != 4'b0000 && !dropped) begin
      expq.push_back({m, 16'(tb_ticks >> 3)});
      lblq.push_back(lbl);
    end
  endtask

  // Monitor: pops and compares while draining is enabled.
  always @(negedge clk) begin
    logic [19:0] e;
    string       l;
    if (drain_on) begin
      if (rd_en) rd_en = 1'b0;
      else if (rd_valid) begin
        if (expq.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R10 unexpected record actual=%0h expected=none", {rd_mask, rd_tag});
        end else begin
          e = expq.pop_front();
          l = lblq.pop_front();
          chk(l, {12'h0, rd_mask, rd_tag}, {12'h0, e});
        end
        rd_en = 1'b1;
      end
    end
  end

  task automatic wait_drain();
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      if (expq.size() == 0 && !rd_valid && !rd_en) break;
    end
    chk("R10 drained", {31'h0, rd_valid}, 32'h0);
    chk("R10 queue empty", expq.size(), 0);
  endtask

  task automatic quiet(string req);
    repeat (16) @(negedge clk);
    chk(req, {30'h0, rd_valid, fifo_empty}, 32'h1);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] v;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R5 reset state
    chk("R5 reset holding", {11'h0, rd_valid, rd_mask, rd_tag}, 32'h0);
    chk("R5 reset flags", {29'h0, fifo_empty, fifo_full, overflow}, 32'h4);

    // R6 transfer delay and R7 fifo empty after transfer
    fire(4'b0001, 4'b0001, 1'b0, "R1/R2/R10 rising in0");
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk("R6 not yet moved", {31'h0, rd_valid}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R6 moved after 8 ticks", {31'h0, rd_valid}, 32'h1);
    chk("R7 fifo empty after move", {31'h0, fifo_empty}, 32'h1);
    repeat (3) @(negedge clk);
    chk("R11 holding unchanged", {31'h0, rd_valid}, 32'h1);
    drain_on = 1'b1;
    wait_drain();

    // R1 wrong-polarity transitions
    fire(4'b0000, 4'b0000, 1'b0, "");
    quiet("R1 falling on rising-only input");
    fire(4'b0010, 4'b0000, 1'b0, "");
    quiet("R1 rising on falling-only input");
    fire(4'b0000, 4'b0010, 1'b0, "R1 falling in1");
    repeat (12) @(negedge clk);
    fire(4'b0100, 4'b0100, 1'b0, "R1 both rise in2");
    repeat (12) @(negedge clk);
    fire(4'b0000, 4'b0100, 1'b0, "R1 both fall in2");
    wait_drain();

    // R4 disabled input
    fire(4'b1000, 4'b0000, 1'b0, "");
    fire(4'b0000, 4'b0000, 1'b0, "");
    quiet("R4 disabled input ignored");

    // R3 merging of simultaneous events
    fire(4'b0101, 4'b0101, 1'b0, "R3 merged in0+in2");
    repeat (12) @(negedge clk);
    fire(4'b0010, 4'b0100, 1'b0, "R3 mixed polarity one hit");
    repeat (12) @(negedge clk);
    fire(4'b1010, 4'b0000, 1'b0, "");
    fire(4'b0000, 4'b0010, 1'b0, "R3/R4 in1 with in3 off");
    wait_drain();

    // R9 overflow: holding + 8 FIFO entries, tenth event dropped
    drain_on = 1'b0;
    for (int i = 0; i < 10; i++) begin
      v = ev_in ^ 4'b0100;
      fire(v, 4'b0100, (i == 9), "R2/R9/R10 burst record");
      @(negedge clk);
    end
    @(negedge clk);
    chk("R9 fifo full", {31'h0, fifo_full}, 32'h1);
    chk("R9 overflow set", {31'h0, overflow}, 32'h1);
    repeat (5) @(negedge clk);
    chk("R9 overflow sticky", {31'h0, overflow}, 32'h1);
    chk("R11 holding valid", {31'h0, rd_valid}, 32'h1);

    // manual read
    begin
      logic [19:0] e;
      string       l;
      e = expq.pop_front();
      l = lblq.pop_front();
      chk(l, {12'h0, rd_mask, rd_tag}, {12'h0, e});
    end
    rd_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    chk("R9 overflow cleared by read", {31'h0, overflow}, 32'h0);
    chk("R8 read clears holding", {31'h0, rd_valid}, 32'h0);
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R8 refill not yet", {31'h0, rd_valid}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 refill after delay", {31'h0, rd_valid}, 32'h1);
    chk("R9 no longer full", {31'h0, fifo_full}, 32'h0);
    drain_on = 1'b1;
    wait_drain();
    chk("R5 fifo empty at end", {31'h0, fifo_empty}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule